// File: doc/BRIEF.md
# Microstep Instruction Fetch Sequencer

This block brings one instruction word in from a synchronous memory and leaves it in an instruction register. It moves the word through a program counter, an address register and a data buffer register. Each clock is one time step. Transfers that do not depend on each other share a step; the main case is the program counter increment, which runs in the same step as the memory read. A transfer that needs the result of an earlier one always waits for the next step.

A pulse on `start_i` starts a fetch. The block holds its memory address on `mem_addr_o` and raises `mem_re_o` in every step that reads memory. The memory must return the word at `mem_addr_o` on `mem_rdata_i` within the step that reads it. That is one cycle after the address is loaded, because the address register acts as the memory's address latch.

Bit 15 of the fetched word selects the operand mode. If the bit is 1, the operand is the low byte of the word and the fetch ends after three steps. If the bit is 0, the low byte is an address. The block then loads that byte back into the address register and reads the operand word from memory, so the fetch takes five steps. `done_o` pulses for one cycle when the results are ready.

Top module: `fetch_seq`

## Requirements
- R1: After reset, `pc_o`, `ir_o` and `operand_o` are 0, and `done_o` and `mem_re_o` are low.
- R2: In the first step after a start is accepted, the address register loads the PC. `mem_re_o` stays low in that step.
- R3: In the second step, `mem_re_o` is high and `mem_addr_o` equals the PC. The word is captured into the data buffer, and the PC increments by one in the same step.
- R4: The instruction register changes only in the third step, which follows the read. It takes the value captured in the second step.
- R5: When bit 15 of the word is 1, `done_o` rises 4 cycles after the start edge. At that point `operand_o` equals bits 7:0 of the word, zero-extended to 16 bits.
- R6: When bit 15 is 0, the fourth step loads bits 7:0 of the instruction register into the address register. The fifth step reads memory at that address with `mem_re_o` high. `operand_o` then holds that memory word, `done_o` rises 6 cycles after the start edge, and `ir_o` still holds the instruction.
- R7: `done_o` is high for exactly one cycle per fetch.
- R8: `start_i` has no effect while a fetch is running. Holding it high through a fetch changes neither the timing nor the PC.
- R9: The PC increments modulo 256, so it goes from 255 to 0.
- R10: The PC changes only in the second step. The operand read in a memory-operand fetch does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a fetch when the block is idle |
| mem_addr_o | output | 8 | Memory address, driven by the address register |
| mem_re_o | output | 1 | High in a step that reads memory |
| mem_rdata_i | input | 16 | Memory word at `mem_addr_o` |
| done_o | output | 1 | One-cycle pulse when the fetch is complete |
| ir_o | output | 16 | Instruction register |
| operand_o | output | 16 | Operand value |
| pc_o | output | 8 | Program counter |

## Verification
The bench fills memory with a mix of immediate words and memory-operand words, and their operand addresses point all over the array. This shows whether the mode bit picks both the right step count and the right operand source. It runs 257 fetches back to back, so the PC passes 255 and wraps to 0, and it tests the modulo increment at the top of memory. For some fetches `start_i` is held high for the whole fetch, which would show a second fetch starting by mistake. It also probes the first two steps of each fetch, which would expose a read merged into the address-load step.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4,
    ST_T5   = 3'd5,
    ST_DONE = 3'd6
  } step_e;

  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mbr_ld;
    logic pc_inc;
    logic ir_ld;
    logic opnd_imm;
    logic opnd_mem;
    logic rd;
  } uop_t;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  mode_imm_i,
  output step_e step_o,
  output uop_t  uop_o,
  output logic  done_o
);
  step_e step_q, step_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_IDLE;
    else         step_q <= step_d;
  end

  always_comb begin
    step_d = step_q;
    uop_o  = '0;
    unique case (step_q)
      ST_IDLE: if (start_i) step_d = ST_T1;
      ST_T1: begin
        uop_o.mar_pc = 1'b1;
        step_d       = ST_T2;
      end
      ST_T2: begin
        uop_o.rd     = 1'b1;
        uop_o.mbr_ld = 1'b1;
        uop_o.pc_inc = 1'b1;
        step_d       = ST_T3;
      end
      ST_T3: begin
        uop_o.ir_ld    = 1'b1;
        uop_o.opnd_imm = mode_imm_i;
        step_d         = mode_imm_i ? ST_DONE : ST_T4;
      end
      ST_T4: begin
        uop_o.mar_ir = 1'b1;
        step_d       = ST_T5;
      end
      ST_T5: begin
        uop_o.rd       = 1'b1;
        uop_o.mbr_ld   = 1'b1;
        uop_o.opnd_mem = 1'b1;
        step_d         = ST_DONE;
      end
      ST_DONE: step_d = ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  assign step_o = step_q;
  assign done_o = (step_q == ST_DONE);
endmodule

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  uop_t              uop_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] operand_o,
  output logic              mode_imm_o
);
  localparam int unsigned MODE_BIT = DATA_W - 1;

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mbr_q, ir_q, opnd_q, imm_ext;

  generate
    if (DATA_W > ADDR_W) begin : g_ext
      assign imm_ext = {{(DATA_W-ADDR_W){1'b0}}, mbr_q[ADDR_W-1:0]};
    end else begin : g_noext
      assign imm_ext = mbr_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      mar_q  <= '0;
      mbr_q  <= '0;
      ir_q   <= '0;
      opnd_q <= '0;
    end else begin
      if (uop_i.mar_pc)   mar_q  <= pc_q;
      if (uop_i.mar_ir)   mar_q  <= ir_q[ADDR_W-1:0];
      if (uop_i.pc_inc)   pc_q   <= pc_q + 1'b1;
      if (uop_i.mbr_ld)   mbr_q  <= mem_rdata_i;
      if (uop_i.ir_ld)    ir_q   <= mbr_q;
      if (uop_i.opnd_imm) opnd_q <= imm_ext;
      // operand taken from the bus in the same edge the buffer captures it
      if (uop_i.opnd_mem) opnd_q <= mem_rdata_i;
    end
  end

  assign mar_o      = mar_q;
  assign pc_o       = pc_q;
  assign ir_o       = ir_q;
  assign operand_o  = opnd_q;
  assign mode_imm_o = mbr_q[MODE_BIT];
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] operand_o,
  output logic [ADDR_W-1:0] pc_o
);
  step_e step_w;
  uop_t  uop_w;
  logic  mode_imm_w;

  fetch_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_imm_i (mode_imm_w),
    .step_o     (step_w),
    .uop_o      (uop_w),
    .done_o     (done_o)
  );

  fetch_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .uop_i       (uop_w),
    .mem_rdata_i (mem_rdata_i),
    .mar_o       (mem_addr_o),
    .pc_o        (pc_o),
    .ir_o        (ir_o),
    .operand_o   (operand_o),
    .mode_imm_o  (mode_imm_w)
  );

  assign mem_re_o = uop_w.rd;
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk
  import fetch_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input step_e             step_i,
  input logic              mem_re_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              done_i,
  input logic [DATA_W-1:0] ir_i,
  input logic [ADDR_W-1:0] pc_i
);
  // R2
  t1_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_T1) |-> !mem_re_i);

  // R3
  pc_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_T2) |=> (pc_i == $past(pc_i) + 1'b1));

  // R10
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i != ST_T2) |=> $stable(pc_i));

  // R4
  ir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i != ST_T3) |=> $stable(ir_i));

  // R6
  opnd_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i == ST_T5) |-> (mem_re_i && mem_addr_i == ir_i[ADDR_W-1:0]));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);
endmodule

bind fetch_seq fetch_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .step_i     (step_w),
  .mem_re_i   (mem_re_o),
  .mem_addr_i (mem_addr_o),
  .done_i     (done_o),
  .ir_i       (ir_o),
  .pc_i       (pc_o)
);

// File: tb/sim_fetch_seq.sv
`timescale 1ns/1ps
module sim_fetch_seq;
  typedef struct {
    logic [15:0] ir;
    logic [15:0] opnd;
    logic [7:0]  pc;
    int          lat;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  mem_addr;
  logic        mem_re;
  logic [15:0] mem_rdata;
  logic        done;
  logic [15:0] ir, operand;
  logic [7:0]  pc;

  logic [15:0] mem [256];
  exp_t        q[$];
  int          cyc = 0;
  int          start_cyc = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [7:0]  pc_model = 8'd0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mem_rdata = mem[mem_addr];

  fetch_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
    .done_o(done), .ir_o(ir), .operand_o(operand), .pc_o(pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // driver: predicts the result, pushes it, runs one fetch
  task automatic run_fetch(input bit hold_start);
    exp_t e;
    logic [15:0] w;
    w = mem[pc_model];
    e.ir = w;
    if (w[15]) begin
      e.opnd = {8'h00, w[7:0]};
      e.lat  = 4;
    end else begin
      e.opnd = mem[w[7:0]];
      e.lat  = 6;
    end
    e.pc = pc_model + 8'd1;
    q.push_back(e);
    @(negedge clk);
    start = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    check("R2 no read in address step", {31'd0, mem_re}, 32'd0);
    @(negedge clk);
    check("R3 read step enable", {31'd0, mem_re}, 32'd1);
    check("R3 read step address", {24'd0, mem_addr}, {24'd0, pc_model});
    while (!done) @(negedge clk);
    start = 1'b0;
    pc_model = pc_model + 8'd1;
    @(negedge clk);
    check("R7 done one cycle", {31'd0, done}, 32'd0);
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check("R8 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(e.ir[15] ? "R5 ir" : "R6 ir", {16'd0, ir}, {16'd0, e.ir});
        check(e.ir[15] ? "R5 operand" : "R6 operand", {16'd0, operand}, {16'd0, e.opnd});
        check("R9 R10 pc", {24'd0, pc}, {24'd0, e.pc});
        check(e.ir[15] ? "R5 latency" : "R6 latency", cyc - start_cyc, e.lat);
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      logic [7:0] ib;
      ib = i[7:0];
      mem[i] = {(i % 3) != 0, ib[6:0], 8'(ib * 8'd7 + 8'd3)};
    end
    repeat (3) @(negedge clk);
    check("R1 pc", {24'd0, pc}, 32'd0);
    check("R1 ir", {16'd0, ir}, 32'd0);
    check("R1 operand", {16'd0, operand}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 re", {31'd0, mem_re}, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 257; k++) run_fetch(k % 5 == 2);
    repeat (8) @(negedge clk);
    check("R8 queue drained", q.size(), 0);
    check("R9 pc wrapped", {24'd0, pc}, 32'd1);
    finish_run();
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule